// File: doc/BRIEF.md
# Multiplexed-Address Dynamic RAM Sequencer with Periodic Refresh

This block sits between a simple single-access host port and a dynamic RAM whose row and column addresses share one set of address pins. For each accepted host request it places the upper half of the host address on the pins and lowers the row strobe. After a programmable delay it switches the pins to the lower half and lowers the column strobe, with the write-enable strobe chosen by the request type. It then raises both strobes and waits out a precharge time before any further access can start.

A free-running interval timer raises a refresh request at a fixed period in clock cycles. The sequencer serves it as a row-only cycle. The row strobe pulses with an internally counted row address, the column strobe stays high and no data moves. The refresh row counter steps once per refresh and wraps over all rows, so that every row is refreshed before its charge decays. All strobes are active low and driven from flip-flops. The data pins are split into an output bus with an output-enable and a separate input bus.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: While synchronous reset is high, and one clock after it, the RAS, CAS and WE strobes are all high, the data output-enable is low, read-valid is low and ready is high. The refresh interval timer and the refresh row counter both restart from zero.
- R2: A request is accepted on a rising edge where host_req and host_ready are both high. On that edge RAS falls with dram_addr equal to host_addr[ADDR_W-1:ADDR_W/2] (the row half) while CAS stays high.
- R3: CAS falls exactly T_RCD clocks after RAS falls, with dram_addr equal to host_addr[ADDR_W/2-1:0] (the column half). RAS stays low for as long as CAS is low.
- R4: For a read (host_we=0), WE stays high while CAS is low. The data on dram_dq_in in the last CAS-low cycle is returned on host_rdata, and host_rvalid is high for exactly one clock.
- R5: For a write (host_we=1), WE is low and dram_dq_oe is high for every cycle that CAS is low, and dram_dq_out equals the request's host_wdata. WE and the output-enable are inactive whenever CAS is high.
- R6: CAS stays low for exactly T_CAS clocks and rises on the same edge as RAS. After any RAS rise, both strobes stay high for at least T_RP clocks before RAS can fall again.
- R7: host_ready is low from the accepting edge until the cycle ends. Without a following refresh, it is low for exactly T_RCD+T_CAS+T_RP clocks.
- R8: A refresh cycle holds RAS low for T_RCD+T_CAS clocks. CAS and WE stay high and dram_dq_oe stays low throughout.
- R9: The refresh row on dram_addr starts at 0 after reset and increments by one after each refresh. It wraps from 2^(ADDR_W/2)-1 to 0.
- R10: A refresh is requested every REF_INTERVAL clocks. When the sequencer is idle, a pending refresh starts before any host request, and host_ready is low while a refresh is pending. A cycle in progress is never cut short by a refresh. With no host traffic, successive refreshes begin exactly REF_INTERVAL clocks apart.
- R11: host_rvalid never pulses for a write cycle or a refresh cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, held until accepted |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Full word address; upper half is the row |
| host_wdata | input | DATA_W | Write data |
| host_ready | output | 1 | Idle with no refresh pending; a request is taken when high |
| host_rdata | output | DATA_W | Read data |
| host_rvalid | output | 1 | One-clock pulse when host_rdata is updated |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_addr | output | ADDR_W/2 | Shared row/column address pins |
| dram_dq_out | output | DATA_W | Data driven to the memory |
| dram_dq_oe | output | 1 | Output-enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data returned by the memory |

## Verification
The hardest case to reach is a refresh that becomes pending while a host cycle is in flight, with the host holding its next request. The refresh has to wait for the precharge to finish and then win over that request. To reach it, the stimulus runs a long back-to-back stream of reads and writes spanning many refresh intervals. The intervals then fall at every phase of the access cycle. A bus monitor checks every RAS and CAS edge for strobe spacing and addresses, and tells refresh cycles from host cycles by the absence of a CAS fall. A long idle stretch then drives the row counter past its wrap point and shows the exact refresh spacing.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_PRE,
    ST_REF
  } seq_state_t;
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int INTERVAL = 781
) (
  input  logic clk,
  input  logic rst,
  input  logic taken,
  output logic pending
);
  localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick    <= '0;
      pending <= 1'b0;
    end else begin
      if (tick == LAST) tick <= '0;
      else              tick <= tick + 1'b1;
      if (tick == LAST) pending <= 1'b1;
      else if (taken)   pending <= 1'b0;
    end
  end
endmodule

// File: rtl/dram_refresh_row.sv
module dram_refresh_row #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk) begin
    if (rst)       row <= '0;
    else if (step) row <= row + 1'b1;
  end
endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
  import dram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RP   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_req,
  input  logic                host_we,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [DATA_W-1:0]   host_wdata,
  output logic                host_ready,
  output logic [DATA_W-1:0]   host_rdata,
  output logic                host_rvalid,
  input  logic                ref_pend,
  input  logic [ADDR_W/2-1:0] ref_row,
  output logic                ref_start,
  output logic                ref_done,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic [ADDR_W/2-1:0] addr,
  output logic [DATA_W-1:0]   dq_out,
  output logic                dq_oe,
  input  logic [DATA_W-1:0]   dq_in
);
  localparam int HALF_W    = ADDR_W / 2;
  localparam int T_RAS_REF = T_RCD + T_CAS;
  localparam int T_MAX     = (T_RAS_REF > T_RP) ? T_RAS_REF : T_RP;
  localparam int CNT_W     = $clog2(T_MAX + 1);

  seq_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [HALF_W-1:0] col_q;
  logic              we_q;
  logic              cnt_zero;

  assign cnt_zero   = (cnt == '0);
  assign host_ready = (state == ST_IDLE) && !ref_pend;
  assign ref_start  = (state == ST_IDLE) && ref_pend;
  assign ref_done   = (state == ST_REF) && cnt_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      ras_n       <= 1'b1;
      cas_n       <= 1'b1;
      we_n        <= 1'b1;
      dq_oe       <= 1'b0;
      addr        <= '0;
      dq_out      <= '0;
      col_q       <= '0;
      we_q        <= 1'b0;
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ref_pend) begin
            state <= ST_REF;
            ras_n <= 1'b0;
            addr  <= ref_row;
            cnt   <= CNT_W'(T_RAS_REF - 1);
          end else if (host_req) begin
            state  <= ST_ROW;
            ras_n  <= 1'b0;
            addr   <= host_addr[ADDR_W-1:HALF_W];
            col_q  <= host_addr[HALF_W-1:0];
            we_q   <= host_we;
            dq_out <= host_wdata;
            cnt    <= CNT_W'(T_RCD - 1);
          end
        end
        ST_ROW: begin
          if (cnt_zero) begin
            state <= ST_COL;
            cas_n <= 1'b0;
            addr  <= col_q;
            we_n  <= ~we_q;
            dq_oe <= we_q;
            cnt   <= CNT_W'(T_CAS - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_COL: begin
          if (cnt_zero) begin
            if (!we_q) begin
              host_rdata  <= dq_in;
              host_rvalid <= 1'b1;
            end
            state <= ST_PRE;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
            cnt   <= CNT_W'(T_RP - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_REF: begin
          if (cnt_zero) begin
            state <= ST_PRE;
            ras_n <= 1'b1;
            cnt   <= CNT_W'(T_RP - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PRE: begin
          if (cnt_zero) state <= ST_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 2,
  parameter int REF_INTERVAL = 781
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_req,
  input  logic                host_we,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [DATA_W-1:0]   host_wdata,
  output logic                host_ready,
  output logic [DATA_W-1:0]   host_rdata,
  output logic                host_rvalid,
  output logic                dram_ras_n,
  output logic                dram_cas_n,
  output logic                dram_we_n,
  output logic [ADDR_W/2-1:0] dram_addr,
  output logic [DATA_W-1:0]   dram_dq_out,
  output logic                dram_dq_oe,
  input  logic [DATA_W-1:0]   dram_dq_in
);
  localparam int HALF_W = ADDR_W / 2;

  logic              ref_pend;
  logic              ref_start;
  logic              ref_done;
  logic [HALF_W-1:0] ref_row;

  dram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .taken   (ref_start),
    .pending (ref_pend)
  );

  dram_refresh_row #(.ROW_W(HALF_W)) u_row (
    .clk  (clk),
    .rst  (rst),
    .step (ref_done),
    .row  (ref_row)
  );

  dram_strobe_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .T_RCD  (T_RCD),
    .T_CAS  (T_CAS),
    .T_RP   (T_RP)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .host_req    (host_req),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_ready  (host_ready),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid),
    .ref_pend    (ref_pend),
    .ref_row     (ref_row),
    .ref_start   (ref_start),
    .ref_done    (ref_done),
    .ras_n       (dram_ras_n),
    .cas_n       (dram_cas_n),
    .we_n        (dram_we_n),
    .addr        (dram_addr),
    .dq_out      (dram_dq_out),
    .dq_oe       (dram_dq_oe),
    .dq_in       (dram_dq_in)
  );
endmodule

// File: rtl/dram_strobe_ctrl_chk.sv
module dram_strobe_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic host_ready,
  input logic host_rvalid,
  input logic dram_ras_n,
  input logic dram_cas_n,
  input logic dram_we_n,
  input logic dram_dq_oe
);
  p_idle_strobes_r1: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> (dram_ras_n && dram_cas_n && dram_we_n && !dram_dq_oe));

  p_cas_inside_ras_r3: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> !dram_ras_n);

  p_rvalid_single_r4: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |=> !host_rvalid);

  p_drive_on_write_r5: assert property (@(posedge clk) disable iff (rst)
    dram_dq_oe |-> (!dram_we_n && !dram_cas_n));

  p_strobes_rise_together_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_cas_n) |-> $rose(dram_ras_n));

  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (rst)
    !dram_ras_n |-> !host_ready);

  p_rvalid_after_read_r11: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |-> $past(!dram_cas_n && dram_we_n));
endmodule

bind dram_strobe_ctrl dram_strobe_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_ready  (host_ready),
  .host_rvalid (host_rvalid),
  .dram_ras_n  (dram_ras_n),
  .dram_cas_n  (dram_cas_n),
  .dram_we_n   (dram_we_n),
  .dram_dq_oe  (dram_dq_oe)
);

// File: tb/sim_dram_strobe_ctrl.sv
module sim_dram_strobe_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int HALF_W = ADDR_W / 2;
  localparam int T_RCD = 2;
  localparam int T_CAS = 2;
  localparam int T_RP = 2;
  localparam int REF_INTERVAL = 40;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int T_TOT = T_RCD + T_CAS + T_RP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_req = 1'b0;
  logic host_we = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [DATA_W-1:0] host_wdata = '0;
  logic host_ready, host_rvalid;
  logic [DATA_W-1:0] host_rdata;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [HALF_W-1:0] dram_addr;
  logic [DATA_W-1:0] dram_dq_out, dram_dq_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_strobe_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_RP(T_RP), .REF_INTERVAL(REF_INTERVAL)
  ) u0 (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_addr(dram_addr), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in)
  );

  // behavioural storage, latching on strobe edges
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] shadow [DEPTH];
  logic [HALF_W-1:0] row_l = '0;
  logic [HALF_W-1:0] col_l = '0;

  always @(negedge dram_ras_n) row_l = dram_addr;
  always @(negedge dram_cas_n) begin
    col_l = dram_addr;
    if (!dram_we_n) mem[{row_l, dram_addr}] = dram_dq_out;
  end
  assign dram_dq_in = (!dram_cas_n && dram_we_n) ? mem[{row_l, col_l}] : '0;

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expectations shared between driver and monitors
  logic              exp_we = 1'b0;
  logic [HALF_W-1:0] exp_row = '0;
  logic [HALF_W-1:0] exp_col = '0;
  logic [DATA_W-1:0] exp_wdata = '0;
  logic [DATA_W-1:0] rd_q [$];

  // strobe monitor state
  logic prev_ras = 1'b1;
  logic prev_cas = 1'b1;
  int ras_lo = 0, cas_lo = 0, hi_n = 100;
  bit cas_seen = 1'b0;
  logic [HALF_W-1:0] ras_row = '0;
  logic [HALF_W-1:0] exp_ref_row = '0;
  int ras_falls = 0, ref_count = 0;
  int cyc = 0, fall_cyc = 0, last_ref_fall = 0, prev_ref_fall = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (prev_ras && !dram_ras_n) begin
        chk(hi_n >= T_RP, "R6 precharge", hi_n, T_RP);
        chk(dram_cas_n == 1'b1, "R2 cas high at row", dram_cas_n, 1);
        ras_row = dram_addr;
        ras_lo = 1; cas_lo = 0; cas_seen = 1'b0;
        ras_falls++; fall_cyc = cyc;
      end else if (!dram_ras_n) begin
        if (prev_cas && !dram_cas_n) begin
          chk(ras_lo == T_RCD, "R3 ras-to-cas", ras_lo, T_RCD);
          chk(dram_addr == exp_col, "R3 column", dram_addr, exp_col);
          chk(ras_row == exp_row, "R2 row", ras_row, exp_row);
          cas_seen = 1'b1;
        end
        ras_lo++;
      end
      if (!dram_cas_n) begin
        cas_lo++;
        chk(dram_we_n == !exp_we, "R5 we level", dram_we_n, !exp_we);
        chk(dram_dq_oe == exp_we, "R5 oe level", dram_dq_oe, exp_we);
        if (exp_we) chk(dram_dq_out == exp_wdata, "R5 wdata", dram_dq_out, exp_wdata);
      end else begin
        chk(dram_we_n && !dram_dq_oe, "R8 no we/oe without cas", dram_we_n, 1);
      end
      if (!prev_ras && dram_ras_n) begin
        if (cas_seen) begin
          chk(cas_lo == T_CAS, "R6 cas width", cas_lo, T_CAS);
          chk(dram_cas_n == 1'b1, "R6 cas rises with ras", dram_cas_n, 1);
        end else begin
          chk(ras_lo == T_RCD + T_CAS, "R8 refresh ras width", ras_lo, T_RCD + T_CAS);
          chk(ras_row == exp_ref_row, "R9 refresh row", ras_row, exp_ref_row);
          exp_ref_row = exp_ref_row + 1'b1;
          ref_count++;
          prev_ref_fall = last_ref_fall;
          last_ref_fall = fall_cyc;
        end
      end
      if (dram_ras_n && dram_cas_n) hi_n++;
      else hi_n = 0;
      prev_ras = dram_ras_n;
      prev_cas = dram_cas_n;
    end
  end

  // scoreboard monitor for read results
  always @(negedge clk) begin
    if (!rst && host_rvalid) begin
      if (rd_q.size() == 0) begin
        chk(1'b0, "R11 unexpected rvalid", 1, 0);
      end else begin
        logic [DATA_W-1:0] e;
        e = rd_q.pop_front();
        chk(host_rdata == e, "R4 read data", host_rdata, e);
      end
    end
  end

  task automatic access(input logic we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    int n;
    int falls0;
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    exp_we = we;
    exp_row = a[ADDR_W-1:HALF_W];
    exp_col = a[HALF_W-1:0];
    exp_wdata = d;
    if (we) shadow[a] = d;
    else rd_q.push_back(shadow[a]);
    host_we = we; host_addr = a; host_wdata = d; host_req = 1'b1;
    #1 falls0 = ras_falls;
    @(negedge clk);
    host_req = 1'b0;
    chk(!host_ready, "R7 ready drops", host_ready, 0);
    n = 0;
    while (!host_ready) begin n++; @(negedge clk); end
    #1;
    if (ras_falls == falls0 + 1) chk(n == T_TOT, "R7 busy length", n, T_TOT);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes in reset", {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    rst = 1'b0;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && !dram_dq_oe, "R1 strobes after reset", dram_ras_n, 1);
    chk(host_ready == 1'b1, "R1 ready after reset", host_ready, 1);
    chk(host_rvalid == 1'b0, "R1 rvalid after reset", host_rvalid, 0);

    // directed patterns, including address extremes
    access(1'b1, 8'h00, 8'h5A);
    access(1'b1, 8'hFF, 8'hFF);
    access(1'b1, 8'h0F, 8'h00);
    access(1'b1, 8'hF0, 8'hA5);
    access(1'b0, 8'h00, 8'h00);
    access(1'b0, 8'hFF, 8'h00);
    access(1'b0, 8'h0F, 8'h00);
    access(1'b0, 8'hF0, 8'h00);
    access(1'b0, 8'h33, 8'h00);

    // idle: refresh spacing (R10)
    repeat (3 * REF_INTERVAL + 10) @(negedge clk);
    chk(last_ref_fall - prev_ref_fall == REF_INTERVAL, "R10 refresh spacing",
        last_ref_fall - prev_ref_fall, REF_INTERVAL);

    // back-to-back traffic across many intervals (R10 priority, no abort)
    begin
      int c0, r0;
      c0 = cyc; r0 = ref_count;
      for (int i = 0; i < 60; i++) access(1'b1, 8'((i * 37) & 8'hFF), 8'((i * 13) ^ 8'hA5));
      for (int i = 0; i < 60; i++) access(1'b0, 8'((i * 37) & 8'hFF), 8'h00);
      chk(ref_count - r0 >= (cyc - c0) / REF_INTERVAL - 1, "R10 refresh under load",
          ref_count - r0, (cyc - c0) / REF_INTERVAL - 1);
    end

    // long idle to wrap the refresh row (R9)
    repeat (20 * REF_INTERVAL) @(negedge clk);
    chk(ref_count > (1 << HALF_W), "R9 refresh row wrapped", ref_count, (1 << HALF_W) + 1);
    repeat (4) @(negedge clk);
    chk(rd_q.size() == 0, "R4 R11 all reads returned once", rd_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule